// File: doc/BRIEF.md
# Burst Read Latency Sequencer

This block is the read-side sequencer of a NOR-style memory that can run synchronous bursts. After reset it is in asynchronous mode and does not start a burst. A configuration write switches it to synchronous mode and holds the configuration: the initial latency, continuous or wrapping-linear bursts, the wrap length and a high-frequency flag. From then on, an address-valid strobe with chip enable low latches a start address. The block counts the initial latency, then presents one word per clock from an internal array model. Its address counter advances after each accepted word.

Extra wait cycles are inserted in two cases. The first is when the burst leaves the first four-word group it started inside, which costs a number of cycles equal to the start offset in that group. The second is when a continuous burst in high-frequency mode crosses a 128-word boundary. The output valid is low during every inserted wait. If a continuous burst steps into a bank flagged busy, the block stops fetching and holds a status word until chip enable rises or a new strobe arrives.

The read port is valid/ready. `rd_valid` high with `rd_ready` low stalls the burst: the word and the address counter hold until the word is accepted. `rd_ready` has no effect while no word is valid, and it has no effect on a held status word. The bank-busy vector, chip enable and the configuration inputs are plain level or pulse controls.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `rd_valid` and `rd_status` are low and the block is in asynchronous mode. In that mode an address strobe starts no burst.
- R2: A `cfg_wr` pulse enables synchronous mode and loads the configuration. A latency field of 0 or 1 is stored as 2. Values 2 to 7 are stored as written.
- R3: When `addr_vld` is sampled with `ce_n` low, `rd_valid` is low in the following cycle. The word at the start address becomes valid exactly L clock edges after the strobe edge, where L is the configured latency.
- R4: While `rd_ready` is high, each later word follows one cycle after the previous one, at the next address. The word at address a equals (a*40503 + 1) mod 2^16.
- R5: For start offset s = addr[1:0], s wait cycles with `rd_valid` low are inserted at the first step out of a group whose low address bits are 11. When s is 0, no wait cycles are inserted.
- R6: In continuous mode with `cfg_fast`=1, a step from an address whose low seven bits are 7Fh adds one wait cycle. With `cfg_fast`=0 it adds none. This cost is added to any R5 waits at the same step.
- R7: In continuous mode, the address after the highest address is 0.
- R8: With `cfg_linear`=1, `cfg_len` codes 00, 01, 10 and 11 select wrap lengths of 8, 16, 32 and 32 words. The burst wraps inside the aligned block of that size, and no R6 cost applies.
- R9: While `rd_valid` is high with `rd_ready` low, `rd_data` holds and the address does not advance. The next word follows one cycle after `rd_ready` returns high.
- R10: `ce_n` high ends a burst, so `rd_valid` is low after the next edge. A later strobe with `ce_n` low starts a new burst.
- R11: A continuous step into a bank whose `bank_busy` bit is set replaces data with a status word. The status word has its MSB set and the bank index in its low bits. While it is shown, `rd_valid` and `rd_status` are high, and the word holds regardless of `rd_ready` until `ce_n` rises or a new strobe arrives.
- R12: Asserting reset during a burst ends it at once and returns the block to asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low; high ends a burst |
| addr_vld | input | 1 | Address strobe; latches `addr_in` and starts a burst |
| addr_in | input | AW | Burst start address |
| cfg_wr | input | 1 | Configuration write pulse |
| cfg_lat | input | 3 | Initial latency in clocks (2..7) |
| cfg_linear | input | 1 | 1 = wrapping linear burst, 0 = continuous |
| cfg_len | input | 2 | Linear wrap length code |
| cfg_fast | input | 1 | High-frequency mode, enables the boundary wait |
| bank_busy | input | 2^(AW-BANK_LOG) | Per-bank busy flags |
| rd_valid | output | 1 | Output word valid |
| rd_ready | input | 1 | Consumer accepts the word |
| rd_data | output | DW | Array word or status word |
| rd_status | output | 1 | `rd_data` carries status |

## Verification
A wrong wait counter or a wrong penalty shows as a `rd_valid` pulse in the wrong cycle. A wrong address register shows as a wrong `rd_data` value. Either fault appears in the first cycle the affected word is due, because the bench models every cycle of a burst. The sweep covers every latency with every start offset and both frequency modes, across the 7Fh/80h boundary. It also covers every linear length at every offset near a block end, so the interaction of the two penalty sources is compared cycle by cycle. A stuck state is caught by the bench within one cycle: a stall that loses its held word, a status word that lets go, or a strobe that is not ignored after reset.

// File: rtl/brl_pkg.sv
package brl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2,
    ST_STAT = 2'd3
  } brl_state_e;

  typedef struct packed {
    logic [2:0] lat;
    logic       linear;
    logic [1:0] len;
    logic       fast;
  } brl_cfg_t;

  localparam logic [2:0] LAT_MIN   = 3'd2;
  localparam logic [2:0] LAT_RESET = 3'd7;
  localparam int unsigned BOUND_BITS = 7;

  // wrap mask of a linear burst: 8, 16 or 32 words
  function automatic logic [5:0] wrap_mask(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd7;
      2'b01:   return 6'd15;
      default: return 6'd31;
    endcase
  endfunction

endpackage

// File: rtl/brl_cfg.sv
module brl_cfg
  import brl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] lat,
  input  logic       linear,
  input  logic [1:0] len,
  input  logic       fast,
  output brl_cfg_t   cfg,
  output logic       sync_on
);

  logic [2:0] lat_ok;
  assign lat_ok = (lat < LAT_MIN) ? LAT_MIN : lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.lat    <= LAT_RESET;
      cfg.linear <= 1'b0;
      cfg.len    <= 2'b00;
      cfg.fast   <= 1'b0;
      sync_on    <= 1'b0;
    end else if (wr) begin
      cfg.lat    <= lat_ok;
      cfg.linear <= linear;
      cfg.len    <= len;
      cfg.fast   <= fast;
      sync_on    <= 1'b1;
    end
  end

endmodule

// File: rtl/brl_addr_gen.sv
module brl_addr_gen
  import brl_pkg::*;
#(
  parameter int AW       = 12,
  parameter int BANK_LOG = 10
) (
  input  logic [AW-1:0]                 cur,
  input  brl_cfg_t                      cfg,
  input  logic [1:0]                    start_off,
  input  logic                          grp_pend,
  input  logic [(1<<(AW-BANK_LOG))-1:0] bank_busy,
  output logic [AW-1:0]                 nxt,
  output logic [2:0]                    penalty,
  output logic                          grp_cross,
  output logic                          busy_hit,
  output logic [((AW>BANK_LOG)?(AW-BANK_LOG):1)-1:0] nxt_bank
);

  localparam int BIW = (AW > BANK_LOG) ? (AW - BANK_LOG) : 1;

  logic [AW-1:0] mask;
  logic          bound_hit;

  assign mask = AW'(wrap_mask(cfg.len));

  always_comb begin
    if (cfg.linear) nxt = (cur & ~mask) | ((cur + AW'(1)) & mask);
    else            nxt = cur + AW'(1);
  end

  assign grp_cross = (cur[1:0] == 2'b11);
  assign bound_hit = !cfg.linear && cfg.fast &&
                     (cur[BOUND_BITS-1:0] == {BOUND_BITS{1'b1}});
  assign penalty   = ((grp_cross && grp_pend) ? {1'b0, start_off} : 3'd0)
                   + {2'b00, bound_hit};

  generate
    if (AW > BANK_LOG) begin : g_banks
      logic [BIW-1:0] cur_bank;
      assign cur_bank = cur[AW-1:BANK_LOG];
      assign nxt_bank = nxt[AW-1:BANK_LOG];
      assign busy_hit = !cfg.linear && (nxt_bank != cur_bank) &&
                        bank_busy[nxt_bank];
    end else begin : g_one_bank
      assign nxt_bank = '0;
      assign busy_hit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/brl_array.sv
module brl_array #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);

  localparam logic [31:0] MULT = 32'd40503;

  logic [31:0] prod;
  assign prod = 32'(rd_addr) * MULT + 32'd1;

  always_ff @(posedge clk) begin
    rd_word <= prod[DW-1:0];
  end

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brl_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int BANK_LOG = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce_n,
  input  logic                          addr_vld,
  input  logic [AW-1:0]                 addr_in,
  input  logic                          cfg_wr,
  input  logic [2:0]                    cfg_lat,
  input  logic                          cfg_linear,
  input  logic [1:0]                    cfg_len,
  input  logic                          cfg_fast,
  input  logic [(1<<(AW-BANK_LOG))-1:0] bank_busy,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output logic [DW-1:0]                 rd_data,
  output logic                          rd_status
);

  localparam int BIW = (AW > BANK_LOG) ? (AW - BANK_LOG) : 1;
  localparam logic [DW-1:0] STAT_FLAG = DW'(1) << (DW - 1);

  brl_cfg_t   cfg;
  logic       sync_mode;

  brl_state_e state_q, state_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [2:0]     wcnt_q, wcnt_d;
  logic [1:0]     off_q, off_d;
  logic           pend_q, pend_d;
  logic [BIW-1:0] sbank_q, sbank_d;

  logic [AW-1:0]  nxt;
  logic [2:0]     penalty;
  logic           grp_cross;
  logic           busy_hit;
  logic [BIW-1:0] nxt_bank;
  logic [DW-1:0]  arr_word;

  brl_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .lat     (cfg_lat),
    .linear  (cfg_linear),
    .len     (cfg_len),
    .fast    (cfg_fast),
    .cfg     (cfg),
    .sync_on (sync_mode)
  );

  brl_addr_gen #(.AW(AW), .BANK_LOG(BANK_LOG)) u_agen (
    .cur       (addr_q),
    .cfg       (cfg),
    .start_off (off_q),
    .grp_pend  (pend_q),
    .bank_busy (bank_busy),
    .nxt       (nxt),
    .penalty   (penalty),
    .grp_cross (grp_cross),
    .busy_hit  (busy_hit),
    .nxt_bank  (nxt_bank)
  );

  // the array is fed the next address so its word lines up with addr_q
  brl_array #(.AW(AW), .DW(DW)) u_arr (
    .clk     (clk),
    .rd_addr (addr_d),
    .rd_word (arr_word)
  );

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wcnt_d  = wcnt_q;
    off_d   = off_q;
    pend_d  = pend_q;
    sbank_d = sbank_q;
    if (ce_n) begin
      state_d = ST_IDLE;
    end else if (addr_vld && sync_mode) begin
      state_d = ST_WAIT;
      addr_d  = addr_in;
      wcnt_d  = cfg.lat - 3'd1;
      off_d   = addr_in[1:0];
      pend_d  = (addr_in[1:0] != 2'b00);
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (wcnt_q == 3'd0) state_d = ST_DATA;
          else                wcnt_d  = wcnt_q - 3'd1;
        end
        ST_DATA: begin
          if (rd_ready) begin
            if (busy_hit) begin
              state_d = ST_STAT;
              sbank_d = nxt_bank;
            end else begin
              addr_d = nxt;
              if (grp_cross) pend_d = 1'b0;
              if (penalty != 3'd0) begin
                state_d = ST_WAIT;
                wcnt_d  = penalty - 3'd1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wcnt_q  <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
      sbank_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wcnt_q  <= wcnt_d;
      off_q   <= off_d;
      pend_q  <= pend_d;
      sbank_q <= sbank_d;
    end
  end

  assign rd_valid  = (state_q == ST_DATA) || (state_q == ST_STAT);
  assign rd_status = (state_q == ST_STAT);
  assign rd_data   = rd_status ? (STAT_FLAG | DW'(sbank_q)) : arr_word;

endmodule

// File: rtl/brl_checker.sv
module brl_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          addr_vld,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          rd_status,
  input logic          sync_on
);

  // R1: nothing is presented while in asynchronous mode
  a_r1_async_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_on |-> !rd_valid);

  // R3: a strobe is followed by at least one empty cycle
  a_r3_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !ce_n) |=> !rd_valid);

  // R9: a stalled word holds
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !rd_status && !ce_n && !addr_vld)
      |=> (rd_valid && $stable(rd_data)));

  // R10: chip enable high ends output
  a_r10_ce_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rd_valid);

  // R11: status word sticks and is always marked valid
  a_r11_status_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !ce_n && !addr_vld) |=> (rd_status && $stable(rd_data)));

  a_r11_status_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> rd_valid);

endmodule

bind burst_read_seq brl_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .addr_vld  (addr_vld),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .rd_status (rd_status),
  .sync_on   (sync_mode)
);

// File: tb/sim_burst_read_seq.sv
module sim_burst_read_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        addr_vld = 1'b0;
  logic [11:0] addr_in = '0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_lat = 3'd7;
  logic        cfg_linear = 1'b0;
  logic [1:0]  cfg_len = 2'b00;
  logic        cfg_fast = 1'b0;
  logic [3:0]  bank_busy = 4'b0000;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        rd_status;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  burst_read_seq #(.AW(12), .DW(16), .BANK_LOG(10)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_vld(addr_vld),
    .addr_in(addr_in), .cfg_wr(cfg_wr), .cfg_lat(cfg_lat),
    .cfg_linear(cfg_linear), .cfg_len(cfg_len), .cfg_fast(cfg_fast),
    .bank_busy(bank_busy), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_status(rd_status)
  );

  function automatic logic [15:0] word(input logic [11:0] a);
    logic [31:0] p;
    p = {20'd0, a} * 32'd40503 + 32'd1;
    return p[15:0];
  endfunction

  function automatic logic [11:0] step(input logic [11:0] a, input bit lin,
                                       input logic [1:0] lc);
    logic [11:0] m;
    m = (lc == 2'b00) ? 12'd7 : (lc == 2'b01) ? 12'd15 : 12'd31;
    return lin ? ((a & ~m) | ((a + 12'd1) & m)) : (a + 12'd1);
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2:0] lat, input bit lin,
                         input logic [1:0] lc, input bit fast);
    @(negedge clk);
    cfg_lat = lat; cfg_linear = lin; cfg_len = lc; cfg_fast = fast;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic strobe(input logic [11:0] a);
    @(negedge clk);
    addr_vld = 1'b1; addr_in = a;
    @(posedge clk);
    @(negedge clk);
    addr_vld = 1'b0;
  endtask

  // cycle-exact model of one burst with rd_ready held high
  task automatic run_words(input logic [11:0] start, input int nwords,
                           input bit lin, input logic [1:0] lc, input bit fast,
                           input int lat, input string req);
    logic [11:0] a = start;
    int nt = lat;
    int n = 0;
    int k = 0;
    int off = int'(start[1:0]);
    bit pend = (start[1:0] != 2'b00);
    while (k < nwords && n < 300) begin
      tick();
      n++;
      if (n == nt) begin
        int pen = 0;
        chk(rd_valid === 1'b1, req, {31'd0, rd_valid}, 32'd1);
        chk(rd_data === word(a), req, {16'd0, rd_data}, {16'd0, word(a)});
        if (pend && a[1:0] == 2'b11) begin pen = off; pend = 1'b0; end
        if (!lin && fast && a[6:0] == 7'h7F) pen++;
        nt = n + 1 + pen;
        a = step(a, lin, lc);
        k++;
      end else begin
        chk(rd_valid === 1'b0, req, {31'd0, rd_valid}, 32'd0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ce_n  = 1'b0;
    tick();
    // R1: reset state and strobe ignored in asynchronous mode
    chk(rd_valid === 1'b0, "R1", {31'd0, rd_valid}, 32'd0);
    chk(rd_status === 1'b0, "R1", {31'd0, rd_status}, 32'd0);
    strobe(12'h000);
    for (int i = 0; i < 12; i++) begin
      tick();
      chk(rd_valid === 1'b0, "R1", {31'd0, rd_valid}, 32'd0);
    end

    // R2: latency 1 is stored as 2
    set_cfg(3'd1, 1'b0, 2'b00, 1'b0);
    strobe(12'h020);
    run_words(12'h020, 4, 1'b0, 2'b00, 1'b0, 2, "R2");

    // R3 R4 R5 R6: every latency, offset and frequency mode across 7Fh
    for (int lat = 2; lat <= 7; lat++)
      for (int f = 0; f < 2; f++)
        for (int off = 0; off < 4; off++) begin
          set_cfg(3'(lat), 1'b0, 2'b00, f[0]);
          strobe(12'h07C + 12'(off));
          run_words(12'h07C + 12'(off), 10, 1'b0, 2'b00, f[0], lat,
                    "R3 R4 R5 R6");
        end

    // R8: linear wraps at every length, fast flag set but no boundary cost
    for (int lc = 0; lc < 4; lc++)
      for (int off = 0; off < 4; off++) begin
        int len = (lc == 0) ? 8 : (lc == 1) ? 16 : 32;
        set_cfg(3'd3, 1'b1, 2'(lc), 1'b1);
        strobe(12'h078 + 12'(off));
        run_words(12'h078 + 12'(off), 2 * len + 2, 1'b1, 2'(lc), 1'b1, 3, "R8");
      end

    // R7: wrap from the top address to zero
    set_cfg(3'd4, 1'b0, 2'b00, 1'b0);
    strobe(12'hFFE);
    run_words(12'hFFE, 5, 1'b0, 2'b00, 1'b0, 4, "R7");

    // R9: back-pressure stalls the word and the counter
    set_cfg(3'd2, 1'b0, 2'b00, 1'b0);
    strobe(12'h200);
    tick();
    chk(rd_valid === 1'b0, "R9", {31'd0, rd_valid}, 32'd0);
    tick();
    chk(rd_data === word(12'h200), "R9", {16'd0, rd_data}, {16'd0, word(12'h200)});
    rd_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(rd_valid === 1'b1, "R9", {31'd0, rd_valid}, 32'd1);
      chk(rd_data === word(12'h200), "R9", {16'd0, rd_data}, {16'd0, word(12'h200)});
    end
    rd_ready = 1'b1;
    tick();
    chk(rd_data === word(12'h201), "R9", {16'd0, rd_data}, {16'd0, word(12'h201)});

    // R11: step into a busy bank shows a held status word
    bank_busy = 4'b0010;
    strobe(12'h3FC);
    run_words(12'h3FC, 4, 1'b0, 2'b00, 1'b0, 2, "R11");
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(rd_valid === 1'b1, "R11", {31'd0, rd_valid}, 32'd1);
      chk(rd_status === 1'b1, "R11", {31'd0, rd_status}, 32'd1);
      chk(rd_data === 16'h8001, "R11", {16'd0, rd_data}, 32'h8001);
      rd_ready = ~rd_ready;
    end
    rd_ready = 1'b1;

    // R10: chip enable ends the burst, a new strobe restarts
    ce_n = 1'b1;
    tick();
    chk(rd_valid === 1'b0, "R10", {31'd0, rd_valid}, 32'd0);
    chk(rd_status === 1'b0, "R10", {31'd0, rd_status}, 32'd0);
    ce_n = 1'b0;
    bank_busy = 4'b0000;
    strobe(12'h010);
    run_words(12'h010, 3, 1'b0, 2'b00, 1'b0, 2, "R10");

    // R12: reset mid-burst returns to asynchronous mode
    strobe(12'h300);
    tick(); tick(); tick();
    rst_n = 1'b0;
    tick();
    chk(rd_valid === 1'b0, "R12", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    strobe(12'h300);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk(rd_valid === 1'b0, "R12", {31'd0, rd_valid}, 32'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule